// File: doc/BRIEF.md
# Four-Channel DMA Host Register Port

This block is the byte-wide host side of a four-channel DMA controller. A processor reaches it through an 8-bit I/O address, an 8-bit write bus, a read bus and two strobes. The block decodes each access and updates the per-channel register set: a 24-bit memory start address, a 16-bit transfer count, a 2-bit operation code and one mask bit per channel. The current values of all of these drive a separate transfer engine. A channel whose mask bit is set must not be serviced by that engine.

The 16-bit address and count registers sit on byte-wide ports. One pointer flip-flop, shared by all channels, selects which half the next access reaches. It starts on the low half and flips after every read or write of one of those ports. Software can force it back to the low half. The top address byte of each channel sits on its own page port. Those ports are scattered, so they are decoded individually. The mask bits can be changed in four ways: one bit at a time, all four at once, all cleared, or all set by a controller reset command.

Top module: `dma_regfile_host`

## Requirements
- R1: After reset every mask bit is 1, the byte pointer selects the low byte, and all addresses, counts and operation codes are 0.
- R2: A write to port 2n (n = 0..3) loads the memory address bits 7:0 of channel n when the pointer is clear, and bits 15:8 when it is set. Port 2n+1 does the same for the transfer count of channel n. Every read or write of ports 0x00 to 0x07 flips the pointer.
- R3: A write to port 0x87, 0x83, 0x81 or 0x82 loads address bits 23:16 of channel 0, 1, 2 or 3 respectively. These writes leave the pointer unchanged, and a read of one of these ports returns the stored byte.
- R4: A write to port 0x0C clears the byte pointer, whatever its state.
- R5: A read of ports 0x00 to 0x07 returns the byte that the pointer currently selects, low or high.
- R6: A write to port 0x0A changes one mask bit. Data bits 1:0 pick the channel, and data bit 2 is the new value (1 sets, 0 clears). Data bits 7:3 are ignored.
- R7: A write to port 0x0F loads mask bits 3:0 from data bits 3:0. Data bits 7:4 are ignored.
- R8: A write to port 0x0E clears all four mask bits.
- R9: A write to port 0x0D sets all four mask bits and clears the byte pointer.
- R10: A write to port 0x0B stores data bits 3:2 as the operation code of the channel picked by data bits 1:0 (00 verify, 01 write, 10 read, 11 reserved, kept as written). Data bits 7:4 are ignored.
- R11: Reads of the write-only ports 0x08 to 0x0F, and of any address the block does not decode, return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| addr | input | 8 | I/O port address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| rdata | output | 8 | Read data, valid combinationally during the read cycle |
| mem_addr_o | output | 96 | Memory addresses, channel n in bits 24n+23:24n |
| xfer_cnt_o | output | 64 | Transfer counts, channel n in bits 16n+15:16n |
| mode_op_o | output | 8 | Operation codes, channel n in bits 2n+1:2n |
| mask_o | output | 4 | Mask bits, one per channel |

## Verification
The byte-pointer ports are tested with several write and read orders. Low/high pairs on different channels show that the pointer is shared and flips on reads as well as writes. A stray single write followed by a pointer clear shows that 0x0C restarts on the low byte. A write straddling a controller reset shows that 0x0D also resets the pointer. Page writes are mixed between pointer-port accesses, which shows that they neither move the pointer nor land on the wrong channel. The mask commands use data with the reserved bits set. This separates correct field decoding from a design that reads the whole byte.

// File: rtl/dma_host_pkg.sv
package dma_host_pkg;

  localparam int unsigned NUM_CH = 4;
  localparam int unsigned CH_W   = 2;
  localparam int unsigned OP_W   = 2;

  typedef enum logic [OP_W-1:0] {
    OP_VERIFY = 2'b00,
    OP_WRITE  = 2'b01,
    OP_READ   = 2'b10,
    OP_RSVD   = 2'b11
  } dma_op_e;

  localparam logic [7:0] PORT_CLR_PTR   = 8'h0C;
  localparam logic [7:0] PORT_MCLR      = 8'h0D;
  localparam logic [7:0] PORT_CLR_MASK  = 8'h0E;
  localparam logic [7:0] PORT_ALL_MASK  = 8'h0F;
  localparam logic [7:0] PORT_ONE_MASK  = 8'h0A;
  localparam logic [7:0] PORT_MODE      = 8'h0B;

  // Page port of each channel; the mapping is irregular.
  function automatic logic [7:0] page_port(input int unsigned ch);
    case (ch)
      0:       page_port = 8'h87;
      1:       page_port = 8'h83;
      2:       page_port = 8'h81;
      default: page_port = 8'h82;
    endcase
  endfunction

endpackage

// File: rtl/dma_port_decode.sv
module dma_port_decode
  import dma_host_pkg::*;
(
  input  logic [7:0]      addr,
  output logic            hit_addr,
  output logic            hit_cnt,
  output logic [CH_W-1:0] word_ch,
  output logic            hit_page,
  output logic [CH_W-1:0] page_ch,
  output logic            hit_clr_ptr,
  output logic            hit_mclr,
  output logic            hit_clr_mask,
  output logic            hit_all_mask,
  output logic            hit_one_mask,
  output logic            hit_mode
);

  localparam int unsigned WORD_PORTS = 2 * NUM_CH;

  logic [NUM_CH-1:0] page_hits;

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_page
      assign page_hits[g] = (addr == page_port(g));
    end
  endgenerate

  always_comb begin
    page_ch = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (page_hits[i]) page_ch = CH_W'(i);
    end
  end

  logic in_word_range;
  assign in_word_range = (addr < 8'(WORD_PORTS));
  assign hit_addr      = in_word_range && !addr[0];
  assign hit_cnt       = in_word_range &&  addr[0];
  assign word_ch       = addr[CH_W:1];
  assign hit_page      = |page_hits;
  assign hit_clr_ptr   = (addr == PORT_CLR_PTR);
  assign hit_mclr      = (addr == PORT_MCLR);
  assign hit_clr_mask  = (addr == PORT_CLR_MASK);
  assign hit_all_mask  = (addr == PORT_ALL_MASK);
  assign hit_one_mask  = (addr == PORT_ONE_MASK);
  assign hit_mode      = (addr == PORT_MODE);

endmodule

// File: rtl/dma_byte_ptr.sv
module dma_byte_ptr (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic clear,
  output logic hi
);

  logic hi_d;
  logic hi_en;

  always_comb begin
    hi_en = step || clear;
    hi_d  = clear ? 1'b0 : !hi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hi <= 1'b0;
    else if (hi_en) hi <= hi_d;
  end

endmodule

// File: rtl/dma_mask_ctrl.sv
module dma_mask_ctrl
  import dma_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              do_mclr,
  input  logic              do_clr_all,
  input  logic              do_load_all,
  input  logic              do_one,
  input  logic [3:0]        wdata_lo,
  output logic [NUM_CH-1:0] mask
);

  logic [NUM_CH-1:0] mask_d;
  logic              mask_en;
  logic [CH_W-1:0]   one_ch;

  assign one_ch = wdata_lo[CH_W-1:0];

  always_comb begin
    mask_d  = mask;
    mask_en = do_mclr || do_clr_all || do_load_all || do_one;
    if (do_mclr)          mask_d = '1;
    else if (do_clr_all)  mask_d = '0;
    else if (do_load_all) mask_d = wdata_lo[NUM_CH-1:0];
    else if (do_one)      mask_d[one_ch] = wdata_lo[2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask <= '1;
    else if (mask_en) mask <= mask_d;
  end

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_host_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_addr,
  input  logic              wr_cnt,
  input  logic              wr_page,
  input  logic              wr_mode,
  input  logic              byte_hi,
  input  logic [7:0]        wdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [CNT_W-1:0]  cnt,
  output logic [OP_W-1:0]   op
);

  localparam int unsigned WORD_W = 16;
  localparam int unsigned PAGE_W = ADDR_W - WORD_W;

  logic [WORD_W-1:0] word_q, word_d;
  logic [PAGE_W-1:0] page_q;
  logic [CNT_W-1:0]  cnt_d;

  always_comb begin
    word_d = word_q;
    cnt_d  = cnt;
    if (byte_hi) begin
      word_d[15:8] = wdata;
      cnt_d[15:8]  = wdata;
    end else begin
      word_d[7:0]  = wdata;
      cnt_d[7:0]   = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      page_q <= '0;
      cnt    <= '0;
      op     <= '0;
    end else begin
      if (wr_addr) word_q <= word_d;
      if (wr_page) page_q <= wdata[PAGE_W-1:0];
      if (wr_cnt)  cnt    <= cnt_d;
      if (wr_mode) op     <= wdata[3:2];
    end
  end

  assign mem_addr = {page_q, word_q};

endmodule

// File: rtl/dma_regfile_host.sv
module dma_regfile_host
  import dma_host_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned CNT_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [7:0]               addr,
  input  logic [7:0]               wdata,
  input  logic                     wr_en,
  input  logic                     rd_en,
  output logic [7:0]               rdata,
  output logic [NUM_CH*ADDR_W-1:0] mem_addr_o,
  output logic [NUM_CH*CNT_W-1:0]  xfer_cnt_o,
  output logic [NUM_CH*OP_W-1:0]   mode_op_o,
  output logic [NUM_CH-1:0]        mask_o
);

  logic            hit_addr, hit_cnt, hit_page;
  logic            hit_clr_ptr, hit_mclr, hit_clr_mask;
  logic            hit_all_mask, hit_one_mask, hit_mode;
  logic [CH_W-1:0] word_ch, page_ch;
  logic            byte_hi;

  dma_port_decode u_dec (
    .addr         (addr),
    .hit_addr     (hit_addr),
    .hit_cnt      (hit_cnt),
    .word_ch      (word_ch),
    .hit_page     (hit_page),
    .page_ch      (page_ch),
    .hit_clr_ptr  (hit_clr_ptr),
    .hit_mclr     (hit_mclr),
    .hit_clr_mask (hit_clr_mask),
    .hit_all_mask (hit_all_mask),
    .hit_one_mask (hit_one_mask),
    .hit_mode     (hit_mode)
  );

  dma_byte_ptr u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .step  ((wr_en || rd_en) && (hit_addr || hit_cnt)),
    .clear (wr_en && (hit_clr_ptr || hit_mclr)),
    .hi    (byte_hi)
  );

  dma_mask_ctrl u_mask (
    .clk         (clk),
    .rst_n       (rst_n),
    .do_mclr     (wr_en && hit_mclr),
    .do_clr_all  (wr_en && hit_clr_mask),
    .do_load_all (wr_en && hit_all_mask),
    .do_one      (wr_en && hit_one_mask),
    .wdata_lo    (wdata[3:0]),
    .mask        (mask_o)
  );

  logic [ADDR_W-1:0] ch_addr [NUM_CH];
  logic [CNT_W-1:0]  ch_cnt  [NUM_CH];

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_ch
      dma_chan_regs #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
      ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_addr  (wr_en && hit_addr && (word_ch == CH_W'(g))),
        .wr_cnt   (wr_en && hit_cnt  && (word_ch == CH_W'(g))),
        .wr_page  (wr_en && hit_page && (page_ch == CH_W'(g))),
        .wr_mode  (wr_en && hit_mode && (wdata[CH_W-1:0] == CH_W'(g))),
        .byte_hi  (byte_hi),
        .wdata    (wdata),
        .mem_addr (ch_addr[g]),
        .cnt      (ch_cnt[g]),
        .op       (mode_op_o[g*OP_W +: OP_W])
      );
      assign mem_addr_o[g*ADDR_W +: ADDR_W] = ch_addr[g];
      assign xfer_cnt_o[g*CNT_W  +: CNT_W]  = ch_cnt[g];
    end
  endgenerate

  always_comb begin
    rdata = 8'h00;
    if (hit_addr)      rdata = byte_hi ? ch_addr[word_ch][15:8] : ch_addr[word_ch][7:0];
    else if (hit_cnt)  rdata = byte_hi ? ch_cnt[word_ch][15:8]  : ch_cnt[word_ch][7:0];
    else if (hit_page) rdata = ch_addr[page_ch][ADDR_W-1:16];
  end

endmodule

// File: rtl/dma_regfile_host_chk.sv
module dma_regfile_host_chk
  import dma_host_pkg::*;
#(
  parameter int unsigned ADDR_W = 24
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [7:0]               addr,
  input logic [7:0]               wdata,
  input logic                     wr_en,
  input logic                     rd_en,
  input logic [7:0]               rdata,
  input logic [NUM_CH*ADDR_W-1:0] mem_addr_o,
  input logic [NUM_CH*OP_W-1:0]   mode_op_o,
  input logic [NUM_CH-1:0]        mask_o,
  input logic                     byte_hi
);

  assert_ptr_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_en || rd_en) && addr < 8'h08) |=> (byte_hi != $past(byte_hi)));

  assert_page0_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 8'h87) |=> (mem_addr_o[ADDR_W-1:16] == $past(wdata)));

  assert_ptr_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == PORT_CLR_PTR) |=> !byte_hi);

  assert_one_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == PORT_ONE_MASK) |=> (mask_o[$past(wdata[1:0])] == $past(wdata[2])));

  assert_all_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == PORT_ALL_MASK) |=> (mask_o == $past(wdata[3:0])));

  assert_clr_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == PORT_CLR_MASK) |=> (mask_o == 4'h0));

  assert_mclr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == PORT_MCLR) |=> (mask_o == 4'hF && !byte_hi));

  assert_mode_store_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == PORT_MODE) |=> (mode_op_o[OP_W*$past(wdata[1:0]) +: OP_W] == $past(wdata[3:2])));

  assert_wo_read_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr >= 8'h08 && addr <= 8'h0F) |-> (rdata == 8'h00));

endmodule

bind dma_regfile_host dma_regfile_host_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .addr       (addr),
  .wdata      (wdata),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .rdata      (rdata),
  .mem_addr_o (mem_addr_o),
  .mode_op_o  (mode_op_o),
  .mask_o     (mask_o),
  .byte_hi    (byte_hi)
);

// File: tb/dma_regfile_host_tb.sv
`timescale 1ns/1ps
module dma_regfile_host_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  rdata;
  logic [95:0] mem_addr_o;
  logic [63:0] xfer_cnt_o;
  logic [7:0]  mode_op_o;
  logic [3:0]  mask_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  dma_regfile_host u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .wdata      (wdata),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .rdata      (rdata),
    .mem_addr_o (mem_addr_o),
    .xfer_cnt_o (xfer_cnt_o),
    .mode_op_o  (mode_op_o),
    .mask_o     (mask_o)
  );

  // {is_read, port, data-or-expected}
  localparam logic [16:0] VEC [0:20] = '{
    {1'b0, 8'h0C, 8'h00},
    {1'b0, 8'h00, 8'h34},
    {1'b0, 8'h00, 8'h12},
    {1'b0, 8'h03, 8'hCD},
    {1'b0, 8'h87, 8'h5A},
    {1'b0, 8'h03, 8'hAB},
    {1'b0, 8'h82, 8'hC3},
    {1'b1, 8'h00, 8'h34},
    {1'b1, 8'h87, 8'h5A},
    {1'b1, 8'h00, 8'h12},
    {1'b1, 8'h03, 8'hCD},
    {1'b1, 8'h03, 8'hAB},
    {1'b1, 8'h82, 8'hC3},
    {1'b0, 8'h06, 8'hEF},
    {1'b0, 8'h0C, 8'h00},
    {1'b0, 8'h06, 8'h77},
    {1'b0, 8'h06, 8'h66},
    {1'b1, 8'h06, 8'h77},
    {1'b1, 8'h06, 8'h66},
    {1'b1, 8'h0B, 8'h00},
    {1'b1, 8'h0F, 8'h00}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_rd(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 v = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    #100000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 mask", 32'(mask_o), 32'hF);
    check("R1 addr0", mem_addr_o[31:0], 32'h0);
    check("R1 modes", 32'(mode_op_o), 32'h0);
    do_rd(8'h00, v);
    check("R1 ptr low", 32'(v), 32'h0);
    do_rd(8'h00, v);

    // vector walk: R2 R3 R4 R5 R11
    for (int i = 0; i < 21; i++) begin
      if (VEC[i][16]) begin
        do_rd(VEC[i][15:8], v);
        check("R5/R3/R11 read", 32'(v), 32'(VEC[i][7:0]));
      end else begin
        do_wr(VEC[i][15:8], VEC[i][7:0]);
      end
    end
    check("R2/R3 ch0 addr", 32'(mem_addr_o[23:0]), 32'h5A1234);
    check("R2 ch1 count", 32'(xfer_cnt_o[31:16]), 32'hABCD);
    check("R4 ch3 addr", 32'(mem_addr_o[95:72]), 32'hC36677);
    check("R2 ch1 addr untouched", 32'(mem_addr_o[47:24]), 32'h0);

    // masks: R8 R6 R7
    do_wr(8'h0E, 8'h00);
    check("R8 clear all", 32'(mask_o), 32'h0);
    do_wr(8'h0A, 8'h06);
    check("R6 set ch2", 32'(mask_o), 32'h4);
    do_wr(8'h0A, 8'hFD);
    check("R6 set ch1 reserved ignored", 32'(mask_o), 32'h6);
    do_wr(8'h0A, 8'h02);
    check("R6 clear ch2", 32'(mask_o), 32'h2);
    do_wr(8'h0F, 8'hA9);
    check("R7 load all", 32'(mask_o), 32'h9);

    // R9: reset command mid-pair
    do_wr(8'h00, 8'h11);
    do_wr(8'h0D, 8'h00);
    check("R9 mask set", 32'(mask_o), 32'hF);
    do_wr(8'h00, 8'h22);
    check("R9 ptr cleared", 32'(mem_addr_o[23:0]), 32'h5A1222);

    // R10 modes
    do_wr(8'h0B, 8'h09);
    check("R10 ch1 read", 32'(mode_op_o[3:2]), 32'h2);
    do_wr(8'h0B, 8'hF7);
    check("R10 ch3 write", 32'(mode_op_o[7:6]), 32'h1);
    do_wr(8'h0B, 8'h0C);
    check("R10 ch0 reserved", 32'(mode_op_o[1:0]), 32'h3);
    check("R10 ch2 untouched", 32'(mode_op_o[5:4]), 32'h0);

    // R11 undecoded port
    do_rd(8'h55, v);
    check("R11 undecoded", 32'(v), 32'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule